// File: doc/BRIEF.md
# Panel Power and Backlight Sequencer

This controller brings a flat-panel display up and down in a safe order. A single request input, `pwr_req`, asks for the panel to be on or off. A one-cycle pulse on `ms_tick` marks every millisecond, and every wait is counted in those pulses. Power-up turns on the logic supply and waits for it to settle. It then releases the video interface and waits again before the backlight lamp is switched on. Power-down runs the steps in the opposite order: the lamp goes off first, then the interface outputs are forced low, then the supply is removed. After the supply is removed, the panel must stay off for a minimum rest time before a new power-up can start.

The video path passes through the block. While the interface is not enabled, every video output is held low. When the interface is released, vertical sync is held low until the source has been seen low. Because of this, the first thing the panel sees on vertical sync is a complete active-high pulse and never the tail of one.

The sequencer has seven states:
- `PH_OFF` (0): everything is off.
- `PH_RAMP` (1): the supply is on and is settling.
- `PH_ARM` (2): the interface is live and the lamp is waiting.
- `PH_RUN` (3): everything is on.
- `PH_LAMPDN` (4): the lamp is off and the interface is still live.
- `PH_INTFDN` (5): the interface is forced low and the supply is still on.
- `PH_REST` (6): the supply is off and the rest time is counting.

The transitions are:
- start: `PH_OFF`→`PH_RAMP`
- settle: `PH_RAMP`→`PH_ARM`
- ignite: `PH_ARM`→`PH_RUN`
- retreat: `PH_RUN`/`PH_ARM`→`PH_LAMPDN`
- quiet: `PH_LAMPDN`→`PH_INTFDN`
- early-abort: `PH_RAMP`→`PH_INTFDN`
- cut: `PH_INTFDN`→`PH_REST`
- rested: `PH_REST`→`PH_OFF`

Top module: `panel_seq_top`

## Requirements
- R1: After reset, `supply_en`, `intf_en` and `lamp_en` are low, `phase` is 0, and `vid_out` and `vsync_out` are low.
- R2: When `pwr_req` is high at a clock edge in phase 0, the block moves to phase 1 at that edge with only `supply_en` high. It stays there until T_SUP_MS+1 ticks have been sampled at later edges. At the following edge it moves to phase 2, where `intf_en` also goes high.
- R3: In phase 2 the lamp stays off until T_LAMP_MS+1 ticks have been sampled. At the following edge the block moves to phase 3 and `lamp_en` goes high.
- R4: Whenever `intf_en` is low, `vid_out` is all zeros and `vsync_out` is low. Whenever `intf_en` is high, `vid_out` equals `vid_in`.
- R5: After `intf_en` rises, `vsync_out` stays low until `vsync_in` has been sampled low at a clock edge with `intf_en` high. From then on, `vsync_out` follows `vsync_in` until `intf_en` falls.
- R6: When `pwr_req` is low in phase 3, `lamp_en` falls first and the block enters phase 4. After T_LAMP_INTF_MS+1 ticks it enters phase 5 and `intf_en` falls. After T_INTF_SUP_MS+1 more ticks it enters phase 6 and `supply_en` falls.
- R7: When `pwr_req` is low in phase 1, the block goes straight to phase 5. When `pwr_req` is low in phase 2, it goes to phase 4.
- R8: Phase 6 lasts until T_OFF_MS+1 ticks have been sampled, and `pwr_req` has no effect during it. The block then returns to phase 0. If `pwr_req` is still high there, it starts again at the next edge.
- R9: Raising `pwr_req` in phase 4 or phase 5 does not stop the shutdown, and the block still passes through phase 6.
- R10: `phase` carries the codes 0 to 6 listed above. The enables always match the current phase: the supply is on in phases 1 to 5, the interface in phases 2 to 4, and the lamp only in phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_req | input | 1 | Panel-on request |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| vid_in | input | VID_W | Pixel, horizontal sync and display-enable bits from the source |
| vsync_in | input | 1 | Vertical sync from the source, active high |
| supply_en | output | 1 | Logic supply enable |
| intf_en | output | 1 | Video interface released |
| lamp_en | output | 1 | Backlight lamp enable |
| vid_out | output | VID_W | Gated video toward the panel |
| vsync_out | output | 1 | Gated vertical sync toward the panel |
| phase | output | 3 | Current sequencer phase code |

## Verification
A wrong state or a miscounted wait shows on the enable outputs and on `phase` in the same cycle that the state register is updated. An early or late transition therefore shows up one clock after the tick that should, or should not, have ended the wait. A stuck or missing vertical-sync arm flag shows on `vsync_out` during the first source pulse after release. A gate that leaks while the interface is disabled shows on `vid_out` in the very cycle that the source data changes. The bench compares every output against its own model on every cycle, so any divergence is reported within one clock.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_RAMP   = 3'd1,
        PH_ARM    = 3'd2,
        PH_RUN    = 3'd3,
        PH_LAMPDN = 3'd4,
        PH_INTFDN = 3'd5,
        PH_REST   = 3'd6
    } phase_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // The wait is over once limit+1 ticks have been seen since the last restart.
    assign done = (cnt_q > limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);

endmodule

// File: rtl/panel_seq_fsm.sv
module panel_seq_fsm
    import panel_seq_pkg::*;
#(
    parameter int unsigned T_SUP_MS       = 10,
    parameter int unsigned T_LAMP_MS      = 180,
    parameter int unsigned T_LAMP_INTF_MS = 0,
    parameter int unsigned T_INTF_SUP_MS  = 0,
    parameter int unsigned T_OFF_MS       = 100
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwr_req,
    input  logic   ms_tick,
    output logic   supply_en,
    output logic   intf_en,
    output logic   lamp_en,
    output phase_e state
);

    localparam int unsigned MAXD = max2(max2(T_SUP_MS, T_LAMP_MS),
                                        max2(max2(T_LAMP_INTF_MS, T_INTF_SUP_MS), T_OFF_MS));
    localparam int unsigned CW   = $clog2(MAXD + 2) + 1;

    phase_e        st_q, st_d;
    logic [CW-1:0] limit;
    logic          wait_done;
    logic          restart;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_OFF;
        else        st_q <= st_d;
    end

    // Length of the wait that belongs to each phase.
    always_comb begin
        unique case (st_q)
            PH_RAMP:   limit = CW'(T_SUP_MS);
            PH_ARM:    limit = CW'(T_LAMP_MS);
            PH_LAMPDN: limit = CW'(T_LAMP_INTF_MS);
            PH_INTFDN: limit = CW'(T_INTF_SUP_MS);
            PH_REST:   limit = CW'(T_OFF_MS);
            default:   limit = '0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_OFF:    if (pwr_req)        st_d = PH_RAMP;
            PH_RAMP:   if (!pwr_req)       st_d = PH_INTFDN;
                       else if (wait_done) st_d = PH_ARM;
            PH_ARM:    if (!pwr_req)       st_d = PH_LAMPDN;
                       else if (wait_done) st_d = PH_RUN;
            PH_RUN:    if (!pwr_req)       st_d = PH_LAMPDN;
            PH_LAMPDN: if (wait_done)      st_d = PH_INTFDN;
            PH_INTFDN: if (wait_done)      st_d = PH_REST;
            PH_REST:   if (wait_done)      st_d = PH_OFF;
            default:                       st_d = PH_OFF;
        endcase
    end

    assign restart = (st_d != st_q);

    panel_seq_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (ms_tick),
        .limit   (limit),
        .done    (wait_done)
    );

    // Output decode.
    always_comb begin
        supply_en = 1'b0;
        intf_en   = 1'b0;
        lamp_en   = 1'b0;
        unique case (st_q)
            PH_RAMP:   supply_en = 1'b1;
            PH_ARM:    begin supply_en = 1'b1; intf_en = 1'b1; end
            PH_RUN:    begin supply_en = 1'b1; intf_en = 1'b1; lamp_en = 1'b1; end
            PH_LAMPDN: begin supply_en = 1'b1; intf_en = 1'b1; end
            PH_INTFDN: supply_en = 1'b1;
            default:   ;
        endcase
    end

    assign state = st_q;

    // R2
    intf_after_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intf_en) |-> $past(supply_en));

    // R3
    lamp_after_intf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lamp_en) |-> $past(intf_en));

    // R6
    supply_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> $past(!intf_en && !lamp_en));

    // R6
    lamp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intf_en) |-> $past(!lamp_en));

    // R8
    rest_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_REST && !wait_done) |=> !supply_en);

endmodule

// File: rtl/panel_seq_gate.sv
module panel_seq_gate #(
    parameter int unsigned VID_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             intf_en,
    input  logic [VID_W-1:0] vid_in,
    input  logic             vsync_in,
    output logic [VID_W-1:0] vid_out,
    output logic             vsync_out
);

    logic vs_armed_q;

    // The arm flag is set once the source sync has been seen low while the interface is live.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          vs_armed_q <= 1'b0;
        else if (!intf_en)   vs_armed_q <= 1'b0;
        else if (!vsync_in)  vs_armed_q <= 1'b1;
    end

    for (genvar i = 0; i < VID_W; i++) begin : g_lane
        assign vid_out[i] = vid_in[i] & intf_en;
    end

    assign vsync_out = vsync_in & vs_armed_q & intf_en;

    // R4
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !intf_en |-> (vid_out == '0 && !vsync_out));

    // R5
    no_partial_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intf_en && !$past(intf_en)) |-> !vsync_out);

endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
    import panel_seq_pkg::*;
#(
    parameter int unsigned VID_W          = 20,
    parameter int unsigned T_SUP_MS       = 10,
    parameter int unsigned T_LAMP_MS      = 180,
    parameter int unsigned T_LAMP_INTF_MS = 0,
    parameter int unsigned T_INTF_SUP_MS  = 0,
    parameter int unsigned T_OFF_MS       = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_req,
    input  logic             ms_tick,
    input  logic [VID_W-1:0] vid_in,
    input  logic             vsync_in,
    output logic             supply_en,
    output logic             intf_en,
    output logic             lamp_en,
    output logic [VID_W-1:0] vid_out,
    output logic             vsync_out,
    output logic [2:0]       phase
);

    phase_e st;

    panel_seq_fsm #(
        .T_SUP_MS       (T_SUP_MS),
        .T_LAMP_MS      (T_LAMP_MS),
        .T_LAMP_INTF_MS (T_LAMP_INTF_MS),
        .T_INTF_SUP_MS  (T_INTF_SUP_MS),
        .T_OFF_MS       (T_OFF_MS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_req   (pwr_req),
        .ms_tick   (ms_tick),
        .supply_en (supply_en),
        .intf_en   (intf_en),
        .lamp_en   (lamp_en),
        .state     (st)
    );

    panel_seq_gate #(.VID_W(VID_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .intf_en   (intf_en),
        .vid_in    (vid_in),
        .vsync_in  (vsync_in),
        .vid_out   (vid_out),
        .vsync_out (vsync_out)
    );

    assign phase = st;

endmodule

// File: tb/panel_seq_top_bench.sv
`timescale 1ns/1ps
module panel_seq_top_bench;

    localparam int VW = 20;
    localparam int T_SUP = 10, T_LAMP = 180, T_LI = 0, T_IS = 0, T_OFF = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_req = 1'b0;
    logic          ms_tick = 1'b0;
    logic [VW-1:0] vid_in = '0;
    logic          vsync_in = 1'b0;
    logic          supply_en, intf_en, lamp_en, vsync_out;
    logic [VW-1:0] vid_out;
    logic [2:0]    phase;

    int tests = 0, fails = 0, cyc = 0;
    bit done_flag = 0;
    string req = "R1";

    int m_st = 0, m_cnt = 0, m_armed = 0;

    always #5 clk = ~clk;

    panel_seq_top u_panel_seq_top (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .ms_tick(ms_tick),
        .vid_in(vid_in), .vsync_in(vsync_in), .supply_en(supply_en),
        .intf_en(intf_en), .lamp_en(lamp_en), .vid_out(vid_out),
        .vsync_out(vsync_out), .phase(phase)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic int lim(input int s);
        case (s)
            1: return T_SUP;
            2: return T_LAMP;
            4: return T_LI;
            5: return T_IS;
            6: return T_OFF;
            default: return 0;
        endcase
    endfunction

    function automatic bit e_sup(input int s);  return (s >= 1 && s <= 5); endfunction
    function automatic bit e_intf(input int s); return (s >= 2 && s <= 4); endfunction
    function automatic bit e_lamp(input int s); return (s == 3);           endfunction

    // Stimulus generators: tick every 4 cycles, changing video, periodic vertical sync.
    always @(negedge clk) begin
        cyc++;
        ms_tick  <= (cyc % 4 == 0);
        vid_in   <= VW'(cyc * 37 + 5);
        vsync_in <= ((cyc % 53) < 6);
    end

    // Reference model and per-cycle comparison.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_armed = 0;
        end else begin
            int nx;
            bit dn;
            dn = (m_cnt > lim(m_st));
            nx = m_st;
            case (m_st)
                0: if (pwr_req) nx = 1;
                1: if (!pwr_req) nx = 5; else if (dn) nx = 2;
                2: if (!pwr_req) nx = 4; else if (dn) nx = 3;
                3: if (!pwr_req) nx = 4;
                4: if (dn) nx = 5;
                5: if (dn) nx = 6;
                6: if (dn) nx = 0;
                default: nx = 0;
            endcase
            if (!e_intf(m_st)) m_armed = 0;
            else if (!vsync_in) m_armed = 1;
            if (nx != m_st) m_cnt = 0;
            else if (ms_tick && !dn) m_cnt++;
            m_st = nx;
        end
        #2;
        if (rst_n && !done_flag) begin
            chk({req, " enables"}, {supply_en, intf_en, lamp_en},
                {e_sup(m_st), e_intf(m_st), e_lamp(m_st)});
            chk("R10 phase", phase, m_st);
            chk("R4 video", vid_out, e_intf(m_st) ? vid_in : '0);
            chk("R5 vsync", vsync_out, e_intf(m_st) && m_armed && vsync_in);
        end
    end

    task automatic wait_phase(input int p);
        while (phase !== 3'(p)) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 enables", {supply_en, intf_en, lamp_en}, 0);
        chk("R1 phase", phase, 0);
        chk("R1 video", {vid_out, vsync_out}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle", {supply_en, intf_en, lamp_en}, 0);

        // R2 and R3: full power-up
        req = "R2";
        pwr_req = 1'b1;
        wait_phase(2);
        req = "R3";
        wait_phase(3);
        chk("R3 lamp on", lamp_en, 1);
        repeat (300) @(negedge clk);

        // R6: ordered shutdown, then R8 rest with request held high
        req = "R6";
        pwr_req = 1'b0;
        wait_phase(6);
        req = "R8";
        pwr_req = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 rest holds off", supply_en, 0);
        wait_phase(1);

        // R7: abort during supply ramp
        req = "R7";
        repeat (12) @(negedge clk);
        pwr_req = 1'b0;
        wait_phase(5);
        chk("R7 ramp abort skips lamp phase", intf_en, 0);

        // R9: request rises during shutdown
        req = "R9";
        pwr_req = 1'b1;
        wait_phase(6);
        chk("R9 shutdown completed", supply_en, 0);
        req = "R8";
        wait_phase(1);

        // R7: abort during lamp wait
        req = "R7";
        wait_phase(2);
        repeat (100) @(negedge clk);
        pwr_req = 1'b0;
        wait_phase(4);
        chk("R7 arm abort keeps interface", {intf_en, lamp_en}, 2'b10);
        req = "R9";
        pwr_req = 1'b1;
        wait_phase(5);
        wait_phase(6);
        req = "R8";
        pwr_req = 1'b0;
        wait_phase(0);
        repeat (20) @(negedge clk);
        chk("R8 stays off without request", phase, 0);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule